// File: doc/BRIEF.md
# Flag-Producing Word Shifter

This block shifts a 32-bit word left logically, right logically or right arithmetically by a count from 0 to 63. Next to the shifted word it returns a set of five condition flags: negative, zero, overflow, carry and extend. The caller supplies the current carry and extend flags with each operation so that a zero count can pass them through.

The counts that fall outside the word need their own handling. A count of zero leaves the word as it is and keeps the old carry. A logical shift of exactly the word width moves one last bit into the carry. A logical shift wider than the word clears both the result and the carry. An arithmetic right shift of the word width or more fills the word with copies of the sign bit. The result and flags are registered. A request is marked by a valid strobe, and the answer appears one clock later.

Top module: `flag_shifter`

## Requirements
- R1: After a synchronous active-low reset, `res_valid`, `res_word` and all five flag outputs read 0.
- R2: With `shift_count` = 0, the result equals the input word, carry equals `carry_in`, and extend equals `extend_in`, for every `shift_kind`.
- R3: `shift_kind` 2'b00 is a logical left shift, and 2'b11 behaves the same way. For counts 1 to 31 the carry is input bit (32 − count).
- R4: `shift_kind` 2'b01 is a logical right shift. For counts 1 to 31 the carry is input bit (count − 1).
- R5: A logical shift by exactly 32 returns 0. The carry is input bit 0 for a left shift and input bit 31 for a right shift.
- R6: A logical shift by 33 to 63 returns 0 with the carry cleared.
- R7: `shift_kind` 2'b10 is an arithmetic right shift. For counts 1 to 31 the vacated bits take the sign bit, and the carry is input bit (count − 1).
- R8: An arithmetic right shift by 32 to 63 returns all bits equal to input bit 31, and the carry equals that bit.
- R9: For any nonzero count, the extend flag takes the same value as the carry flag.
- R10: Negative is bit 31 of the result, zero is set when the result is all zeros, and overflow always reads 0.
- R11: `res_valid` is `op_valid` delayed by one clock. When `op_valid` is low, `res_word` and the flags keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Operation request strobe |
| op_word | input | 32 | Word to shift |
| shift_count | input | 6 | Shift distance, 0 to 63 |
| shift_kind | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 logical left |
| carry_in | input | 1 | Current carry flag |
| extend_in | input | 1 | Current extend flag |
| res_valid | output | 1 | Result strobe, one clock after the request |
| res_word | output | 32 | Shifted word |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| flag_x | output | 1 | Extend flag |

## Verification
The only state is the output register, so any fault shows up one clock after the request that triggers it. A wrong clamp of the distance or a wrong choice of fill bit shows first in the carry at counts 32 and 33 and in arithmetic shifts of negative words. A missed bit reversal on the left-shift path shows as a mirrored result at every nonzero left count. A faulty hold path corrupts the outputs during idle cycles, and the bench compares the outputs on every clock, including idle ones.

// File: rtl/shf_pkg.sv
// Package: shared types for the flag-producing shifter.
// Assumes a 2-bit operation code; the code 2'b11 is treated as a left shift.
package shf_pkg;

    typedef enum logic [1:0] {
        SHK_LSL = 2'b00,
        SHK_LSR = 2'b01,
        SHK_ASR = 2'b10,
        SHK_ALT = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
        logic x;
    } ccr_t;

endpackage

// File: rtl/shf_amount.sv
// Module: shf_amount
// Decodes the operation code and clamps the raw count to the barrel's range.
// Assumes the count field can express values above WIDTH. Logical shifts past
// WIDTH are flagged for flushing. Arithmetic shifts past WIDTH are clamped to WIDTH,
// which fills the word with the sign bit and moves the sign into the carry.
module shf_amount
    import shf_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int CNT_W = 6,
    localparam int AMT_W = $clog2(WIDTH + 1)
) (
    input  logic [CNT_W-1:0] count,
    input  shift_kind_e      kind,
    output logic [AMT_W-1:0] amt,
    output logic             is_right,
    output logic             is_arith,
    output logic             flush,
    output logic             nonzero
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WIDTH);

    // Purpose: classify the operation and derive the clamped distance.
    always_comb begin
        is_right = (kind == SHK_LSR) || (kind == SHK_ASR);
        is_arith = (kind == SHK_ASR);
        nonzero  = (count != '0);
        flush    = !is_arith && (count > CNT_FULL);
        amt      = (count >= CNT_FULL) ? AMT_W'(WIDTH) : AMT_W'(count);
    end

endmodule

// File: rtl/shf_barrel.sv
// Module: shf_barrel
// A logarithmic right-shifting barrel over WIDTH+1 bits. The extra low bit catches
// the last bit shifted out, which becomes the carry. A left shift is done by reversing
// the word, shifting it right, and reversing it back.
// Assumes amt <= WIDTH.
module shf_barrel #(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH + 1),
    localparam int EXT_W = WIDTH + 1
) (
    input  logic [WIDTH-1:0] val,
    input  logic [AMT_W-1:0] amt,
    input  logic             is_right,
    input  logic             is_arith,
    output logic [WIDTH-1:0] res,
    output logic             carry
);

    logic [WIDTH-1:0] src;
    logic [WIDTH-1:0] shifted;
    logic [EXT_W-1:0] stg [0:AMT_W];
    logic             fill;

    assign fill   = is_right & is_arith & val[WIDTH-1];
    assign stg[0] = {src, 1'b0};

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_rev
            // Purpose: mirror the word on the way in and out for left shifts.
            assign src[gi] = is_right ? val[gi] : val[WIDTH-1-gi];
            assign res[gi] = is_right ? shifted[gi] : shifted[WIDTH-1-gi];
        end
        for (gi = 0; gi < AMT_W; gi++) begin : g_stage
            localparam int SH = 1 << gi;
            // Purpose: one power-of-two step of the right shift with fill.
            assign stg[gi+1] = amt[gi] ? {{SH{fill}}, stg[gi][EXT_W-1:SH]} : stg[gi];
        end
    endgenerate

    assign shifted = stg[AMT_W][EXT_W-1:1];
    assign carry   = stg[AMT_W][0];

endmodule

// File: rtl/shf_flags.sv
// Module: shf_flags
// Forms the condition flags from the final word and the carry out of the barrel.
// Assumes the caller has already forced the word and the carry for flushed shifts.
module shf_flags
    import shf_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] word,
    input  logic             carry,
    input  logic             nonzero,
    input  logic             c_prev,
    input  logic             x_prev,
    output ccr_t             ccr
);

    // Purpose: derive N/Z from the word and C/X from the count rule.
    always_comb begin
        ccr.n = word[WIDTH-1];
        ccr.z = (word == '0);
        ccr.v = 1'b0;
        ccr.c = nonzero ? carry : c_prev;
        ccr.x = nonzero ? carry : x_prev;
    end

endmodule

// File: rtl/flag_shifter.sv
// Module: flag_shifter (top)
// A registered word shifter with condition flags. It has one pipeline stage.
// Assumes synchronous active-low reset. The outputs keep their values while no
// request is presented.
module flag_shifter
    import shf_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int CNT_W = 6,
    localparam int AMT_W = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [WIDTH-1:0] op_word,
    input  logic [CNT_W-1:0] shift_count,
    input  logic [1:0]       shift_kind,
    input  logic             carry_in,
    input  logic             extend_in,
    output logic             res_valid,
    output logic [WIDTH-1:0] res_word,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_v,
    output logic             flag_c,
    output logic             flag_x
);

    logic [AMT_W-1:0] amt;
    logic             is_right, is_arith, flush, nonzero;
    logic [WIDTH-1:0] bar_res, word_sel;
    logic             bar_carry, carry_sel;
    ccr_t             ccr_d, ccr_q;
    shift_kind_e      kind;

    assign kind = shift_kind_e'(shift_kind);

    shf_amount #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_amount (
        .count    (shift_count),
        .kind     (kind),
        .amt      (amt),
        .is_right (is_right),
        .is_arith (is_arith),
        .flush    (flush),
        .nonzero  (nonzero)
    );

    shf_barrel #(.WIDTH(WIDTH)) u_barrel (
        .val      (op_word),
        .amt      (amt),
        .is_right (is_right),
        .is_arith (is_arith),
        .res      (bar_res),
        .carry    (bar_carry)
    );

    // Purpose: zero the word and the carry for logical shifts past the width.
    always_comb begin
        word_sel  = flush ? '0 : bar_res;
        carry_sel = flush ? 1'b0 : bar_carry;
    end

    shf_flags #(.WIDTH(WIDTH)) u_flags (
        .word    (word_sel),
        .carry   (carry_sel),
        .nonzero (nonzero),
        .c_prev  (carry_in),
        .x_prev  (extend_in),
        .ccr     (ccr_d)
    );

    // Purpose: output register; capture on a request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_word  <= '0;
            ccr_q     <= '0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                res_word <= word_sel;
                ccr_q    <= ccr_d;
            end
        end
    end

    assign flag_n = ccr_q.n;
    assign flag_z = ccr_q.z;
    assign flag_v = ccr_q.v;
    assign flag_c = ccr_q.c;
    assign flag_x = ccr_q.x;

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WIDTH);

    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && shift_count == '0) |=> (res_word == $past(op_word)
            && flag_c == $past(carry_in) && flag_x == $past(extend_in))); // R2

    AST_FAR_LOGIC: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && shift_kind != 2'b10 && shift_count > CNT_FULL)
            |=> (res_word == '0 && !flag_c)); // R6

    AST_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && shift_kind == 2'b10 && shift_count >= CNT_FULL)
            |=> (res_word == {WIDTH{$past(op_word[WIDTH-1])}}
                 && flag_c == $past(op_word[WIDTH-1]))); // R8

    AST_EXT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && shift_count != '0) |=> (flag_x == flag_c)); // R9

    AST_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !flag_v); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && $past(rst_n)) |=> ($stable(res_word) && $stable(ccr_q))); // R11

endmodule

// File: tb/flag_shifter_bench.sv
// Bench: a behavioural bit-at-a-time reference, compared with the outputs every clock.
module flag_shifter_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [31:0] op_word;
    logic [5:0]  shift_count;
    logic [1:0]  shift_kind;
    logic        carry_in, extend_in;
    logic        res_valid;
    logic [31:0] res_word;
    logic        flag_n, flag_z, flag_v, flag_c, flag_x;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    // expected state of the outputs
    logic        e_valid = 0;
    logic [31:0] e_word  = 0;
    logic        e_n = 0, e_z = 0, e_v = 0, e_c = 0, e_x = 0;
    string       e_tag = "R1";

    always #2 clk = ~clk;

    flag_shifter u_flag_shifter (
        .clk, .rst_n, .op_valid, .op_word, .shift_count, .shift_kind,
        .carry_in, .extend_in, .res_valid, .res_word,
        .flag_n, .flag_z, .flag_v, .flag_c, .flag_x
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference: shift one bit at a time and track the last bit that falls out.
    task automatic ref_shift(input logic [31:0] v, input int cnt, input logic [1:0] op,
                             input logic ci, input logic xi,
                             output logic [31:0] r, output logic c, output logic x);
        r = v;
        c = ci;
        for (int i = 0; i < cnt; i++) begin
            if (op == 2'b01 || op == 2'b10) begin
                c = r[0];
                r = (op == 2'b10) ? {r[31], r[31:1]} : {1'b0, r[31:1]};
            end else begin
                c = r[31];
                r = {r[30:0], 1'b0};
            end
        end
        x = (cnt == 0) ? xi : c;
    endtask

    function automatic string tag_of(input int cnt, input logic [1:0] op);
        if (cnt == 0) return "R2";
        if (op == 2'b10) return (cnt >= 32) ? "R8" : "R7";
        if (cnt == 32) return "R5";
        if (cnt > 32) return "R6";
        return (op == 2'b01) ? "R4" : "R3";
    endfunction

    task automatic compare_now();
        chk("R11", "res_valid", 32'(res_valid), 32'(e_valid));
        chk(e_tag, "res_word", res_word, e_word);
        chk(e_tag, "flag_c", 32'(flag_c), 32'(e_c));
        chk((e_tag == "R2") ? "R2" : "R9", "flag_x", 32'(flag_x), 32'(e_x));
        chk("R10", "flag_n", 32'(flag_n), 32'(e_n));
        chk("R10", "flag_z", 32'(flag_z), 32'(e_z));
        chk("R10", "flag_v", 32'(flag_v), 32'(e_v));
    endtask

    // One clock: check what the last request produced, then present the next.
    task automatic step(input logic vld, input logic [31:0] v, input int cnt,
                        input logic [1:0] op, input logic ci, input logic xi);
        logic [31:0] r;
        logic        c, x;
        @(negedge clk);
        compare_now();
        op_valid    = vld;
        op_word     = v;
        shift_count = 6'(cnt);
        shift_kind  = op;
        carry_in    = ci;
        extend_in   = xi;
        e_valid     = vld;
        if (vld) begin
            ref_shift(v, cnt, op, ci, xi, r, c, x);
            e_word = r;
            e_c    = c;
            e_x    = x;
            e_n    = r[31];
            e_z    = (r == 0);
            e_v    = 1'b0;
            e_tag  = tag_of(cnt, op);
        end else begin
            e_tag = "R11";
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'h8000_0001;
        pats[1] = 32'h7FFF_FFFE;
        pats[2] = 32'hA5C3_0F96;
        pats[3] = 32'h0000_0000;
        rst_n = 0; op_valid = 0; op_word = 32'hFFFF_FFFF; shift_count = 6'd5;
        shift_kind = 0; carry_in = 1; extend_in = 1;
        repeat (3) @(posedge clk);
        // R1: reset state, checked with the reset still applied
        @(negedge clk);
        compare_now();
        rst_n = 1;
        // sweep every count and every code over several patterns
        for (int p = 0; p < 4; p++)
            for (int op = 0; op < 4; op++)
                for (int cnt = 0; cnt < 64; cnt++)
                    step(1'b1, pats[p] ^ 32'(cnt * 32'h0101_0101), cnt, 2'(op),
                         1'(cnt + op), 1'(cnt + p + 1));
        // R11: idle cycles hold the last result
        step(1'b1, 32'h1234_5678, 4, 2'b01, 1'b0, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b0, 32'hDEAD_BEEF, 1, 2'b00, 1'b1, 1'b0);
        // random traffic with idle gaps
        for (int i = 0; i < 1500; i++)
            step(1'($urandom % 5 != 0), $urandom, int'($urandom % 64), 2'($urandom),
                 1'($urandom), 1'($urandom));
        step(1'b0, 0, 0, 0, 0, 0);
        step(1'b0, 0, 0, 0, 0, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule